// File: doc/BRIEF.md
# Level-Tracking Masked Interrupt Controller

This block gathers a vector of level-sensitive interrupt lines into one request toward a processor. Every line is brought into the local clock domain through a short synchronizer chain. The synchronized value is registered into a pending vector on every clock. Pending bits follow their lines: a bit rises when its line is high and falls when the line drops. Software cannot set or clear them.

Software controls a mask register through a small synchronous register port that takes full 32-bit words only. The single request output is a registered OR over the bitwise AND of mask and pending. The pending vector can be read at its own offset. Two further offsets take writes and ignore them. Any other offset, and any access without all byte enables set, is refused and reported on a one-cycle error pulse.

Top module: `lvl_irq_ctrl`

## Requirements
- R1: After reset the mask and pending vectors are all zero, and `irq_req`, `bus_rdata` and `bus_err` are low.
- R2: Pending bit n follows `irq_in[n]` with no software action. A level applied to the input is visible in the pending vector three clock edges later: two synchronizer flops, then the pending register.
- R3: `irq_req` is high exactly when the mask AND pending is nonzero one clock edge earlier. A mask write therefore changes the request on the edge after the write edge, and an input change reaches the request on the fourth edge.
- R4: A full-word write to byte offset 0x04 replaces the whole mask. A full-word read of 0x04 returns the mask in the low bits of `bus_rdata` on the clock after the read is sampled.
- R5: A full-word read of byte offset 0x0C returns the pending vector on the clock after the read is sampled.
- R6: Full-word writes to byte offsets 0x00 and 0x14 are accepted. They change no state and raise no error.
- R7: A read of any byte offset other than 0x04 or 0x0C returns zero and pulses `bus_err` high for one clock.
- R8: A write to any byte offset other than 0x00, 0x04 or 0x14 changes no state and pulses `bus_err` high for one clock.
- R9: An access whose `bus_be` is not 4'b1111 is refused. A write changes nothing and a read returns zero. Either one pulses `bus_err` for one clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wr | input | 1 | Write strobe, sampled on the clock edge |
| bus_rd | input | 1 | Read strobe, sampled on the clock edge |
| bus_be | input | 4 | Byte enables; only all-ones is accepted |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered, zero when no valid read |
| bus_err | output | 1 | One-cycle pulse for a refused access |
| irq_in | input | 32 | Raw level interrupt inputs |
| irq_req | output | 1 | Combined interrupt request |

## Verification
On every cycle, the assertions check three relations. The pending vector must equal the last synchronizer stage one edge earlier. The request must reflect the masked pending vector of the previous cycle. The mask must hold steady unless a valid mask write occurs. They also check that refused reads return zero with an error pulse, that partial accesses flag an error, and that writes to the two ignored offsets stay silent.

Some properties are end-to-end and visible only at the ports, so only the directed scenarios can show them. These are the exact three- and four-edge latency from an input level to the pending read and to the request, and the fact that a pending bit clears when its line drops. The scenarios also show that the mask value read back and the request stay unchanged after an ignored or partial write.

// File: rtl/lvl_irq_pkg.sv
package lvl_irq_pkg;
    localparam int ADDR_W  = 8;
    localparam int DATA_W  = 32;
    localparam int BE_W    = DATA_W / 8;

    localparam logic [ADDR_W-1:0] OFS_MASK   = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_PEND   = 8'h0C;
    localparam logic [ADDR_W-1:0] OFS_SINK_A = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_SINK_B = 8'h14;

    typedef enum logic [1:0] {
        RSEL_NONE = 2'd0,
        RSEL_MASK = 2'd1,
        RSEL_PEND = 2'd2
    } rsel_e;
endpackage

// File: rtl/lvl_irq_sync.sv
module lvl_irq_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] raw_in,
    output logic [WIDTH-1:0] pend_q
);
    typedef struct packed {
        logic [STAGES-1:0][WIDTH-1:0] chain;
        logic [WIDTH-1:0]             pend;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.chain[0] = raw_in;
        for (int s = 1; s < STAGES; s++) begin
            st_d.chain[s] = st_q.chain[s-1];
        end
        st_d.pend = st_q.chain[STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend_q = st_q.pend;

    AST_PEND_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> pend_q == $past(st_q.chain[STAGES-1])); // R2
endmodule

// File: rtl/lvl_irq_regport.sv
module lvl_irq_regport
    import lvl_irq_pkg::*;
#(
    parameter int NUM_IRQ = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [BE_W-1:0]    bus_be,
    input  logic [DATA_W-1:0]  bus_wdata,
    input  logic [NUM_IRQ-1:0] pend,
    output logic [NUM_IRQ-1:0] mask_q,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic               bus_err
);
    typedef struct packed {
        logic [NUM_IRQ-1:0] mask;
        logic [DATA_W-1:0]  rdata;
        logic               err;
    } port_st_t;

    port_st_t st_d, st_q;
    logic     full_word;
    logic     wr_mask, wr_sink, wr_bad, rd_bad;
    rsel_e    rsel;

    always_comb begin
        full_word = &bus_be;
        rsel = RSEL_NONE;
        if (bus_rd && full_word) begin
            if (bus_addr == OFS_MASK)      rsel = RSEL_MASK;
            else if (bus_addr == OFS_PEND) rsel = RSEL_PEND;
        end
        rd_bad  = bus_rd && (rsel == RSEL_NONE);
        wr_mask = bus_wr && full_word && (bus_addr == OFS_MASK);
        wr_sink = bus_wr && full_word &&
                  ((bus_addr == OFS_SINK_A) || (bus_addr == OFS_SINK_B));
        wr_bad  = bus_wr && !(wr_mask || wr_sink);

        st_d = st_q;
        if (wr_mask) st_d.mask = bus_wdata[NUM_IRQ-1:0];
        case (rsel)
            RSEL_MASK: st_d.rdata = DATA_W'(st_q.mask);
            RSEL_PEND: st_d.rdata = DATA_W'(pend);
            default:   st_d.rdata = '0;
        endcase
        st_d.err = rd_bad || wr_bad;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mask_q    = st_q.mask;
    assign bus_rdata = st_q.rdata;
    assign bus_err   = st_q.err;

    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && (&bus_be) && bus_addr == OFS_MASK) |=> $stable(mask_q)); // R4
    AST_BAD_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr != OFS_MASK && bus_addr != OFS_PEND)
        |=> (bus_rdata == '0 && bus_err)); // R7
    AST_PARTIAL_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_rd || bus_wr) && !(&bus_be)) |=> bus_err); // R9
    AST_SINK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !bus_rd && (&bus_be) &&
         (bus_addr == OFS_SINK_A || bus_addr == OFS_SINK_B))
        |=> (!bus_err && $stable(mask_q))); // R6
endmodule

// File: rtl/lvl_irq_combine.sv
module lvl_irq_combine #(
    parameter int NUM_IRQ = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IRQ-1:0] mask,
    input  logic [NUM_IRQ-1:0] pend,
    output logic               req_q
);
    typedef struct packed {
        logic req;
    } comb_st_t;

    comb_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.req = |(mask & pend);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign req_q = st_q.req;
endmodule

// File: rtl/lvl_irq_ctrl.sv
module lvl_irq_ctrl
    import lvl_irq_pkg::*;
#(
    parameter int NUM_IRQ     = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [BE_W-1:0]    bus_be,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic               bus_err,
    input  logic [NUM_IRQ-1:0] irq_in,
    output logic               irq_req
);
    logic [NUM_IRQ-1:0] pend_q;
    logic [NUM_IRQ-1:0] mask_q;

    lvl_irq_sync #(.WIDTH(NUM_IRQ), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_in (irq_in),
        .pend_q (pend_q)
    );

    lvl_irq_regport #(.NUM_IRQ(NUM_IRQ)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_be    (bus_be),
        .bus_wdata (bus_wdata),
        .pend      (pend_q),
        .mask_q    (mask_q),
        .bus_rdata (bus_rdata),
        .bus_err   (bus_err)
    );

    lvl_irq_combine #(.NUM_IRQ(NUM_IRQ)) u_comb (
        .clk   (clk),
        .rst_n (rst_n),
        .mask  (mask_q),
        .pend  (pend_q),
        .req_q (irq_req)
    );

    AST_REQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> irq_req == ($past(mask_q & pend_q) != '0)); // R3
endmodule

// File: tb/lvl_irq_ctrl_test.sv
module lvl_irq_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_err;
    logic [31:0] irq_in = '0;
    logic        irq_req;

    int n_chk = 0;
    int n_bad = 0;
    logic        last_err;
    logic [31:0] last_rd;

    always #5 clk = ~clk;

    lvl_irq_ctrl uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_err(bus_err), .irq_in(irq_in),
        .irq_req(irq_req)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_be = be; bus_wr = 1'b1;
        @(negedge clk);
        last_err = bus_err;
        bus_wr = 1'b0; bus_be = '0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [3:0] be);
        @(negedge clk);
        bus_addr = a; bus_be = be; bus_rd = 1'b1;
        @(negedge clk);
        last_rd = bus_rdata; last_err = bus_err;
        bus_rd = 1'b0; bus_be = '0;
    endtask

    task automatic settle_inputs(input logic [31:0] v);
        @(negedge clk);
        irq_in = v;
        repeat (5) @(negedge clk);
    endtask

    task automatic t_reset;
        chk("R1 req", {31'b0, irq_req}, 32'h0);
        chk("R1 err", {31'b0, bus_err}, 32'h0);
        chk("R1 rdata", bus_rdata, 32'h0);
        rd(8'h04, 4'hF); chk("R1 mask", last_rd, 32'h0);
        rd(8'h0C, 4'hF); chk("R1 pend", last_rd, 32'h0);
    endtask

    task automatic t_mask_rw;
        wr(8'h04, 32'hA5C3_0F18, 4'hF);
        chk("R4 write err", {31'b0, last_err}, 32'h0);
        rd(8'h04, 4'hF);
        chk("R4 readback", last_rd, 32'hA5C3_0F18);
        chk("R4 read err", {31'b0, last_err}, 32'h0);
        wr(8'h04, 32'h0000_0001, 4'hF);
        rd(8'h04, 4'hF);
        chk("R4 whole replace", last_rd, 32'h0000_0001);
        wr(8'h04, 32'h0, 4'hF);
    endtask

    task automatic t_pending_track;
        @(negedge clk);
        irq_in = 32'h8000_0011;
        @(negedge clk); @(negedge clk);
        rd(8'h0C, 4'hF);
        chk("R2 pend after 3 edges", last_rd, 32'h8000_0011);
        chk("R5 pend read err", {31'b0, last_err}, 32'h0);
        settle_inputs(32'h8000_0001);
        rd(8'h0C, 4'hF);
        chk("R2 pend clears with line", last_rd, 32'h8000_0001);
        settle_inputs(32'h0);
        rd(8'h0C, 4'hF);
        chk("R5 pend all low", last_rd, 32'h0);
    endtask

    task automatic t_req_combine;
        settle_inputs(32'h0000_0100);
        chk("R3 masked off", {31'b0, irq_req}, 32'h0);
        wr(8'h04, 32'h0000_0100, 4'hF);
        chk("R3 req not yet", {31'b0, irq_req}, 32'h0);
        @(negedge clk);
        chk("R3 req after mask", {31'b0, irq_req}, 32'h1);
        irq_in = 32'h0;
        repeat (3) @(negedge clk);
        chk("R3 req held 3 edges", {31'b0, irq_req}, 32'h1);
        @(negedge clk);
        chk("R3 req drops edge 4", {31'b0, irq_req}, 32'h0);
        irq_in = 32'h0000_0200;
        repeat (5) @(negedge clk);
        chk("R3 other line masked", {31'b0, irq_req}, 32'h0);
        irq_in = 32'h0000_0300;
        repeat (4) @(negedge clk);
        chk("R3 edge 4 rise", {31'b0, irq_req}, 32'h1);
    endtask

    task automatic t_sink_writes;
        wr(8'h00, 32'hFFFF_FFFF, 4'hF);
        chk("R6 sink A err", {31'b0, last_err}, 32'h0);
        wr(8'h14, 32'h0, 4'hF);
        chk("R6 sink B err", {31'b0, last_err}, 32'h0);
        rd(8'h04, 4'hF);
        chk("R6 mask intact", last_rd, 32'h0000_0100);
        chk("R6 req intact", {31'b0, irq_req}, 32'h1);
        rd(8'h0C, 4'hF);
        chk("R6 pend intact", last_rd, 32'h0000_0300);
    endtask

    task automatic t_bad_read;
        rd(8'h08, 4'hF);
        chk("R7 bad rd data", last_rd, 32'h0);
        chk("R7 bad rd err", {31'b0, last_err}, 32'h1);
        @(negedge clk);
        chk("R7 err one cycle", {31'b0, bus_err}, 32'h0);
        rd(8'h00, 4'hF);
        chk("R7 rd of write-only", {31'b0, last_err}, 32'h1);
        rd(8'h05, 4'hF);
        chk("R7 unaligned rd", last_rd, 32'h0);
    endtask

    task automatic t_bad_write;
        wr(8'h0C, 32'hFFFF_FFFF, 4'hF);
        chk("R8 wr pend err", {31'b0, last_err}, 32'h1);
        wr(8'h24, 32'h0, 4'hF);
        chk("R8 wr far err", {31'b0, last_err}, 32'h1);
        rd(8'h04, 4'hF);
        chk("R8 mask intact", last_rd, 32'h0000_0100);
        rd(8'h0C, 4'hF);
        chk("R8 pend intact", last_rd, 32'h0000_0300);
    endtask

    task automatic t_partial;
        wr(8'h04, 32'h0, 4'b0111);
        chk("R9 partial wr err", {31'b0, last_err}, 32'h1);
        rd(8'h04, 4'hF);
        chk("R9 mask kept", last_rd, 32'h0000_0100);
        chk("R9 req kept", {31'b0, irq_req}, 32'h1);
        rd(8'h0C, 4'b0001);
        chk("R9 partial rd data", last_rd, 32'h0);
        chk("R9 partial rd err", {31'b0, last_err}, 32'h1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_mask_rw();
        t_pending_track();
        t_req_combine();
        t_sink_writes();
        t_bad_read();
        t_bad_write();
        t_partial();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule